// File: doc/BRIEF.md
# MII Transmit FCS Regenerator

This block sits in the 4-bit MII transmit path between a MAC and a PHY. Logic further upstream may have changed the frame contents, so the frame check sequence the MAC produced is no longer valid. The block passes the preamble and the start-of-frame delimiter through untouched. It computes a new CRC-32 over every nibble between the delimiter and the old check sequence. It then drops the eight old check nibbles and sends the freshly computed ones in their place.

The nibble stream runs through an eight-stage buffer followed by a registered output stage. The enable, error and data signals therefore all come out exactly nine clocks after they went in. The CRC does not read the block's input. It reads the stream as it leaves the buffer. As a result, the register holds the CRC of exactly the covered nibbles at the moment the falling input enable shows that the buffer now contains the old check sequence.

A four-state controller follows the buffer tail:
- ST_IDLE: no frame at the tail.
- ST_HUNT: preamble is passing.
- ST_BODY: covered nibbles are being accumulated.
- ST_FCS: new check nibbles are being emitted.

Transitions:
- ST_IDLE goes to ST_HUNT when the tail enable rises. It goes straight to ST_BODY if that first nibble is the delimiter.
- ST_HUNT goes to ST_BODY on the delimiter nibble, or back to ST_IDLE if the enable drops first.
- ST_BODY goes to ST_FCS on the input enable fall, which also loads the first new nibble. It goes to ST_IDLE if the tail enable drops without a fall having been seen.
- ST_FCS goes to ST_IDLE after the seventh further nibble.

Top module: `fcs_regen_mii`

## Requirements
- R1: While reset is asserted, out_txd, out_txen and out_txer are all zero. This holds immediately for a reset applied in the middle of a frame, and a later frame is handled normally.
- R2: out_txen equals in_txen from nine clocks earlier, so every output frame has exactly as many nibbles as the input frame.
- R3: out_txer equals in_txer from nine clocks earlier, on every nibble including the replaced check nibbles.
- R4: Every nibble other than the replaced check nibbles appears on out_txd unchanged, nine clocks after it was presented. This covers preamble nibbles 0x5, the delimiter 0xD, idle nibbles and the frame body.
- R5: The last eight nibbles of a frame are replaced by the one's complement of the CRC-32 (polynomial 0x04C11DB7) over the covered nibbles. Term x^31 goes first. Within each nibble, txd[0] carries the higher-order term, so the first nibble is {~c28,~c29,~c30,~c31} read from bit 3 down to bit 0. Bit 0 of every input nibble enters the CRC first.
- R6: The CRC is preset to 0xFFFFFFFF for each frame. Earlier traffic never affects the check sequence of a later frame.
- R7: Coverage starts with the nibble after the first 0xD seen since the enable rose. It works for any preamble length, including none. A 0xD inside the covered part does not restart coverage.
- R8: A replacement happens only when at least eight nibbles follow the delimiter. With exactly eight, the new check nibbles are all zero. With fewer, the frame passes through unchanged.
- R9: Running the MSB-first CRC-32 over the output's covered nibbles together with the new check nibbles leaves the residue 0xC704DD7B. In the bit-reflected form this is 0xDEBB20E3.
- R10: Two frames separated by a single idle clock are both regenerated correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_txd | input | 4 | Transmit nibble from the MAC side |
| in_txen | input | 1 | Transmit enable from the MAC side |
| in_txer | input | 1 | Transmit error from the MAC side |
| out_txd | output | 4 | Transmit nibble toward the PHY |
| out_txen | output | 1 | Transmit enable toward the PHY, delayed nine clocks |
| out_txer | output | 1 | Transmit error toward the PHY, delayed nine clocks |

## Verification
The properties assume that the inputs are held at zero during reset, and that a frame's enable stays high until its last check nibble. They also assume no frame ends while the previous one's new check nibbles are still leaving. That rules out frames shorter than eight nibbles closer than eight clocks apart. The stimulus drives zeros during every reset and builds complete frames with a delimiter. Frames are separated by at least one idle clock, and the only sub-minimum frames are isolated runts followed by long gaps.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

    localparam int NIB_W    = 4;
    localparam int CRC_W    = 32;
    localparam int FCS_NIBS = CRC_W / NIB_W;

    localparam logic [CRC_W-1:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_PRESET = '1;

    typedef struct packed {
        logic             en;
        logic             er;
        logic [NIB_W-1:0] d;
    } mii_nib_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HUNT,
        ST_BODY,
        ST_FCS
    } regen_state_t;

    // One nibble of the MSB-first recurrence; d[0] is the first wire bit.
    function automatic logic [CRC_W-1:0] crc_nib_next(
        input logic [CRC_W-1:0] c,
        input logic [NIB_W-1:0] d,
        input logic [CRC_W-1:0] poly
    );
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 0; i < NIB_W; i++) begin
            fb = r[CRC_W-1] ^ d[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

    // Top NIB_W bits of w placed so the highest term leaves on bit 0.
    function automatic logic [NIB_W-1:0] fcs_wire_nib(input logic [CRC_W-1:0] w);
        logic [NIB_W-1:0] n;
        for (int i = 0; i < NIB_W; i++) n[i] = w[CRC_W-1-i];
        return n;
    endfunction

endpackage

// File: rtl/fcsr_nib_delay.sv
module fcsr_nib_delay
    import fcsr_pkg::*;
#(
    parameter int DEPTH = FCS_NIBS
) (
    input  logic     clk,
    input  logic     rst_n,
    input  mii_nib_t din,
    output mii_nib_t head,
    output mii_nib_t tail
);

    mii_nib_t [DEPTH-1:0] stage;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage <= '0;
        else        stage <= {stage[DEPTH-2:0], din};
    end

    assign head = stage[0];
    assign tail = stage[DEPTH-1];

endmodule

// File: rtl/fcsr_crc32_nib.sv
module fcsr_crc32_nib
    import fcsr_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [NIB_W-1:0] nib,
    output logic [CRC_W-1:0] crc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     crc_q <= CRC_PRESET;
        else if (clear) crc_q <= CRC_PRESET;
        else if (step)  crc_q <= crc_nib_next(crc_q, nib, POLY);
    end

endmodule

// File: rtl/fcsr_seq_ctrl.sv
module fcsr_seq_ctrl
    import fcsr_pkg::*;
#(
    parameter logic [NIB_W-1:0] SFD_CODE = 4'hD
) (
    input  logic         clk,
    input  logic         rst_n,
    input  mii_nib_t     tail,
    input  logic         head_en,
    input  logic         in_en,
    output regen_state_t st,
    output logic         load_fcs,
    output logic         crc_clear,
    output logic         crc_step
);

    localparam int CNT_W = $clog2(FCS_NIBS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FCS_NIBS - 2);

    regen_state_t     nx;
    logic [CNT_W-1:0] cnt;
    logic             fall;

    assign fall = head_en && !in_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= nx;
            cnt <= (st == ST_FCS) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nx = st;
        unique case (st)
            ST_IDLE: if (tail.en) nx = (tail.d == SFD_CODE) ? ST_BODY : ST_HUNT;
            ST_HUNT: begin
                if (!tail.en)                nx = ST_IDLE;
                else if (tail.d == SFD_CODE) nx = ST_BODY;
            end
            ST_BODY: begin
                if (fall)          nx = ST_FCS;
                else if (!tail.en) nx = ST_IDLE;
            end
            ST_FCS:  if (cnt == CNT_LAST) nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_fcs  = (st == ST_BODY) && fall;
        crc_clear = (st != ST_BODY);
        crc_step  = (st == ST_BODY) && !fall && tail.en;
    end

endmodule

// File: rtl/fcs_regen_mii.sv
module fcs_regen_mii
    import fcsr_pkg::*;
#(
    parameter logic [3:0]  SFD_CODE = 4'hD,
    parameter logic [31:0] POLY     = 32'h04C11DB7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] in_txd,
    input  logic       in_txen,
    input  logic       in_txer,
    output logic [3:0] out_txd,
    output logic       out_txen,
    output logic       out_txer
);

    mii_nib_t         din;
    mii_nib_t         head;
    mii_nib_t         tail;
    regen_state_t     st;
    logic             load_fcs;
    logic             crc_clear;
    logic             crc_step;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] fcs_hold;
    logic [CRC_W-1:0] fcs_new;
    logic             sub_q;

    assign din     = {in_txen, in_txer, in_txd};
    assign fcs_new = ~crc_q;

    fcsr_nib_delay #(.DEPTH(FCS_NIBS)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .head  (head),
        .tail  (tail)
    );

    fcsr_seq_ctrl #(.SFD_CODE(SFD_CODE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tail      (tail),
        .head_en   (head.en),
        .in_en     (in_txen),
        .st        (st),
        .load_fcs  (load_fcs),
        .crc_clear (crc_clear),
        .crc_step  (crc_step)
    );

    fcsr_crc32_nib #(.POLY(POLY)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (crc_clear),
        .step  (crc_step),
        .nib   (tail.d),
        .crc_q (crc_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_txd  <= '0;
            out_txen <= 1'b0;
            out_txer <= 1'b0;
            fcs_hold <= '0;
            sub_q    <= 1'b0;
        end else begin
            out_txen <= tail.en;
            out_txer <= tail.er;
            sub_q    <= load_fcs || (st == ST_FCS);
            if (load_fcs) begin
                out_txd  <= fcs_wire_nib(fcs_new);
                fcs_hold <= fcs_new << NIB_W;
            end else if (st == ST_FCS) begin
                out_txd  <= fcs_wire_nib(fcs_hold);
                fcs_hold <= fcs_hold << NIB_W;
            end else begin
                out_txd  <= tail.d;
            end
        end
    end

endmodule

// File: rtl/fcs_regen_mii_chk.sv
module fcs_regen_mii_chk
    import fcsr_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   in_txd,
    input logic         in_txen,
    input logic         in_txer,
    input logic [3:0]   out_txd,
    input logic         out_txen,
    input logic         out_txer,
    input logic         sub_q,
    input regen_state_t st,
    input logic [31:0]  crc_q
);

    localparam int LAT = FCS_NIBS + 1;

    logic [4:0] since;
    logic [3:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= '0;
            run   <= '0;
        end else begin
            if (since < 5'(LAT)) since <= since + 1'b1;
            run <= sub_q ? run + 1'b1 : '0;
        end
    end

    assert_txen_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 5'(LAT)) |-> (out_txen == $past(in_txen, 9)));

    assert_txer_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 5'(LAT)) |-> (out_txer == $past(in_txer, 9)));

    assert_pass_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((since >= 5'(LAT)) && !sub_q) |-> (out_txd == $past(in_txd, 9)));

    assert_fcs_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sub_q |-> out_txen);

    assert_fcs_from_body_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_q) |-> ($past(st) == ST_BODY));

    assert_preset_hunt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HUNT) |-> (crc_q == 32'hFFFF_FFFF));

    assert_fcs_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        run <= 4'(FCS_NIBS));

endmodule

bind fcs_regen_mii fcs_regen_mii_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_txd   (in_txd),
    .in_txen  (in_txen),
    .in_txer  (in_txer),
    .out_txd  (out_txd),
    .out_txen (out_txen),
    .out_txer (out_txer),
    .sub_q    (sub_q),
    .st       (st),
    .crc_q    (crc_q)
);

// File: tb/fcs_regen_mii_test.sv
module fcs_regen_mii_test;

    localparam int LATC = 9;
    localparam int MAXN = 1024;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] in_txd = '0;
    logic       in_txen = 1'b0;
    logic       in_txer = 1'b0;
    logic [3:0] out_txd;
    logic       out_txen;
    logic       out_txer;

    always #10 clk = ~clk;

    fcs_regen_mii uut (
        .clk(clk), .rst_n(rst_n),
        .in_txd(in_txd), .in_txen(in_txen), .in_txer(in_txer),
        .out_txd(out_txd), .out_txen(out_txen), .out_txer(out_txer)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [5:0] s_v   [MAXN];
    logic [5:0] e_v   [MAXN];
    logic [5:0] log_v [MAXN];
    bit         s_fc  [MAXN];
    int         s_len;

    // {pre nibbles, body bytes, seed, old-FCS mode, error flag}
    localparam logic [31:0] VEC [7] = '{
        {8'd15, 8'd60, 8'd1, 4'd0, 4'd0},
        {8'd15, 8'd64, 8'd2, 4'd1, 4'd0},
        {8'd7,  8'd20, 8'd3, 4'd2, 4'd1},
        {8'd1,  8'd14, 8'd4, 4'd1, 4'd0},
        {8'd15, 8'd60, 8'd1, 4'd0, 4'd0},
        {8'd3,  8'd33, 8'd9, 4'd1, 4'd1},
        {8'd0,  8'd16, 8'd5, 4'd0, 4'd0}
    };

    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input bit en, input bit er, input logic [3:0] ds, input logic [3:0] de, input bit fc);
        s_v[s_len]  = {en, er, ds};
        e_v[s_len]  = {en, er, de};
        s_fc[s_len] = fc;
        s_len++;
    endtask

    task automatic add_gap(input int n);
        for (int i = 0; i < n; i++) push(0, 0, 4'h0, 4'h0, 0);
    endtask

    task automatic add_frame(input int pre, input int nbytes, input int seed, input int mode, input bit er);
        logic [31:0] c, good, old;
        logic [7:0]  b, ob, gb;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < pre; i++) push(1, 0, 4'h5, 4'h5, 0);
        push(1, 0, 4'hD, 4'hD, 0);
        for (int i = 0; i < nbytes; i++) begin
            b = 8'(seed * 29 + i * 71 + (i >> 3));
            c = ref_crc(c, b);
            push(1, er && (i == 3), b[3:0], b[3:0], 0);
            push(1, 0, b[7:4], b[7:4], 0);
        end
        good = ~c;
        old  = (mode == 0) ? good : (mode == 1) ? (good ^ 32'h0001_0080) : 32'h0;
        for (int k = 0; k < 4; k++) begin
            ob = old[8*k +: 8];
            gb = good[8*k +: 8];
            push(1, 0, ob[3:0], gb[3:0], 1);
            push(1, er && (k == 2), ob[7:4], gb[7:4], 1);
        end
    endtask

    task automatic add_runt(input int pre, input int nafter);
        for (int i = 0; i < pre; i++) push(1, 0, 4'h5, 4'h5, 0);
        push(1, 0, 4'hD, 4'hD, 0);
        for (int i = 0; i < nafter; i++) begin
            if (nafter >= 8 && i >= nafter - 8) push(1, 0, 4'(i + 3), 4'h0, 1);
            else                                push(1, 0, 4'(i + 3), 4'(i + 3), 0);
        end
    endtask

    task automatic run_stream();
        @(negedge clk);
        for (int i = 0; i < s_len + LATC; i++) begin
            if (i >= LATC) log_v[i-LATC] = {out_txen, out_txer, out_txd};
            if (i < s_len) {in_txen, in_txer, in_txd} = s_v[i];
            else           {in_txen, in_txer, in_txd} = '0;
            @(negedge clk);
        end
    endtask

    task automatic compare_stream(input string tag);
        int m_en = 0, m_er = 0, m_bd = 0, m_fc = 0;
        logic [31:0] a_en = 0, x_en = 0, a_er = 0, x_er = 0, a_bd = 0, x_bd = 0, a_fc = 0, x_fc = 0;
        for (int i = 0; i < s_len; i++) begin
            if (log_v[i][5] !== e_v[i][5]) begin
                if (m_en == 0) begin a_en = 32'(log_v[i][5]); x_en = 32'(e_v[i][5]); end
                m_en++;
            end
            if (log_v[i][4] !== e_v[i][4]) begin
                if (m_er == 0) begin a_er = 32'(log_v[i][4]); x_er = 32'(e_v[i][4]); end
                m_er++;
            end
            if (log_v[i][3:0] !== e_v[i][3:0]) begin
                if (s_fc[i]) begin
                    if (m_fc == 0) begin a_fc = 32'(log_v[i][3:0]); x_fc = 32'(e_v[i][3:0]); end
                    m_fc++;
                end else begin
                    if (m_bd == 0) begin a_bd = 32'(log_v[i][3:0]); x_bd = 32'(e_v[i][3:0]); end
                    m_bd++;
                end
            end
        end
        check(m_en == 0, {"R2 enable delay/length ", tag}, a_en, x_en);
        check(m_er == 0, {"R3 error delay ", tag}, a_er, x_er);
        check(m_bd == 0, {"R4 pass-through nibbles ", tag}, a_bd, x_bd);
        check(m_fc == 0, {"R5 R6 R8 regenerated check nibbles ", tag}, a_fc, x_fc);
    endtask

    task automatic check_residue(input string tag);
        int          phase;
        bit          half;
        logic [31:0] c;
        logic [3:0]  lo;
        logic        en;
        logic [3:0]  d;
        phase = 0; half = 0; c = '1; lo = '0;
        for (int i = 0; i < s_len; i++) begin
            en = log_v[i][5];
            d  = log_v[i][3:0];
            if (!en) begin
                if (phase == 2) check(c == 32'hDEBB_20E3, {"R9 residue ", tag}, c, 32'hDEBB_20E3);
                phase = 0;
            end else if (phase != 2) begin
                phase = (d == 4'hD) ? 2 : 1;
                c = '1; half = 0;
            end else if (!half) begin
                lo = d; half = 1;
            end else begin
                c = ref_crc(c, {d, lo}); half = 0;
            end
        end
    endtask

    initial begin
        #3000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] c;
        logic [7:0]  txt [9];

        // R1: outputs at reset
        repeat (3) @(negedge clk);
        check({out_txd, out_txen, out_txer} == 6'b0, "R1 reset outputs", 32'({out_txd, out_txen, out_txer}), 0);
        rst_n = 1'b1;

        // Model sanity: check value of the ASCII digits 1..9
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 9; i++) begin
            txt[i] = 8'h31 + 8'(i);
            c = ref_crc(c, txt[i]);
        end
        check(~c == 32'hCBF4_3926, "R5 reference model", ~c, 32'hCBF4_3926);

        // Vector walk: R2..R7, R9; no reset between frames exercises R6
        for (int v = 0; v < 7; v++) begin
            s_len = 0;
            add_frame(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]),
                      int'(VEC[v][7:4]), VEC[v][0]);
            add_gap(12);
            run_stream();
            compare_stream($sformatf("R7 vec%0d", v));
            check_residue($sformatf("vec%0d", v));
        end

        // R8: runt with six nibbles after delimiter passes unchanged
        s_len = 0;
        add_runt(5, 6);
        add_gap(14);
        run_stream();
        compare_stream("R8 runt6");

        // R8: exactly eight after delimiter -> all-zero check nibbles
        s_len = 0;
        add_runt(5, 8);
        add_gap(14);
        run_stream();
        compare_stream("R8 empty body");

        // R10: back-to-back frames with one idle clock
        s_len = 0;
        add_frame(15, 60, 11, 1, 0);
        add_gap(1);
        add_frame(15, 46, 12, 2, 0);
        add_gap(12);
        run_stream();
        compare_stream("R10 back-to-back");
        check_residue("R10 back-to-back");

        // R1: reset in the middle of a frame, then recovery
        s_len = 0;
        add_frame(15, 60, 7, 0, 0);
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            {in_txen, in_txer, in_txd} = s_v[i];
            @(negedge clk);
        end
        rst_n = 1'b0;
        {in_txen, in_txer, in_txd} = '0;
        #1;
        check({out_txd, out_txen, out_txer} == 6'b0, "R1 mid-frame reset", 32'({out_txd, out_txen, out_txer}), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        s_len = 0;
        add_frame(15, 50, 8, 1, 0);
        add_gap(12);
        run_stream();
        compare_stream("R1 after reset");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule